// File: doc/BRIEF.md
# Sponge Permutation Nonlinear Round Stage

This block carries out the closing half of one round of a 25-lane sponge permutation. It takes a state of twenty-five lanes, each `LANE_W` bits wide (a power of two from 1 to 64), and applies three steps in a fixed order. The first moves whole lanes to new positions. The second mixes each five-bit row with a complemented-AND term. The third folds a supplied round-constant lane into lane (0,0). All three steps are combinational, and a single output register captures the result.

The block is meant to sit directly behind the linear half of a round, which lives in a separate block. The surrounding control supplies the round constant for the current round, runs the round counter, and handles absorbing and squeezing. A strobe on `in_valid` marks a state word to be processed. The result appears on `out_state` with `out_valid` high on the following cycle.

Top module: `perm_nl_stage`

## Requirements
- R1: Lane (x,y), with x and y in 0..4, occupies bits `[LANE_W*(5*y+x) +: LANE_W]` of both `in_state` and `out_state`. Bit z of a lane is bit `LANE_W*(5*y+x)+z` of the bus.
- R2: After the rearrangement step, lane (x,y) holds input lane ((x+3y) mod 5, x). Bit positions within a lane do not change.
- R3: The row mix replaces each bit [x,y,z] with itself XOR ((NOT bit [(x+1) mod 5,y,z]) AND bit [(x+2) mod 5,y,z]). It reads only the rearranged state, and each row is mixed on its own.
- R4: Bit z of `round_const` is XORed into bit z of lane (0,0) after the row mix. The other 24 lanes do not depend on `round_const`.
- R5: Bit z of the result depends only on bit z of every input lane and on bit z of `round_const`.
- R6: On a rising clock edge with `in_valid` high, `out_state` takes the result of the rearrangement, then the mix, then the injection, all applied to the present `in_state` and `round_const`.
- R7: `out_valid` equals `in_valid` delayed by exactly one cycle. A synchronous active-high `rst` clears `out_valid` at the next edge, whatever the value of `in_valid`.
- R8: While `in_valid` is low, `out_state` keeps its last value, no matter how `in_state` or `round_const` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears `out_valid` |
| in_valid | input | 1 | Marks `in_state` and `round_const` as valid for capture |
| in_state | input | 25*LANE_W | Input state, lanes packed as in R1 |
| round_const | input | LANE_W | Round-constant lane injected into lane (0,0) |
| out_valid | output | 1 | Goes high one cycle after `in_valid` |
| out_state | output | 25*LANE_W | Registered result of the stage |

## Verification
A wrong lane source in the rearrangement appears one cycle after the strobe. A single set input bit lands in the wrong output lanes, or it moves the row-mix partner bit to the wrong place. An error in the row mix or the constant injection changes particular bits of that same registered word, so a sweep of walking bits, pseudo-random states and every constant value exposes it at the first affected vector. A fault in the valid register or the load enable appears within one cycle: `out_valid` is misaligned, or `out_state` drifts while the block is idle.

// File: rtl/perm_nl_pkg.sv
package perm_nl_pkg;

  localparam int NUM_LANES = 25;
  localparam int ROW_LEN   = 5;

  // flat lane number of lane (x,y)
  function automatic int lane_pos(input int x, input int y);
    return ROW_LEN * y + x;
  endfunction

  // lane that the rearrangement moves into position (x,y)
  function automatic int shuffle_src(input int x, input int y);
    return lane_pos((x + 3 * y) % ROW_LEN, x);
  endfunction

  // row neighbour at distance d, wrapping around the row
  function automatic int row_step(input int x, input int d);
    return (x + d) % ROW_LEN;
  endfunction

endpackage

// File: rtl/perm_lane_shuffle.sv
module perm_lane_shuffle
  import perm_nl_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [NUM_LANES*LANE_W-1:0] src_state,
  output logic [NUM_LANES*LANE_W-1:0] dst_state
);

  for (genvar gy = 0; gy < ROW_LEN; gy++) begin : g_row
    for (genvar gx = 0; gx < ROW_LEN; gx++) begin : g_col
      localparam int DST = lane_pos(gx, gy);
      localparam int SRC = shuffle_src(gx, gy);
      assign dst_state[LANE_W*DST +: LANE_W] = src_state[LANE_W*SRC +: LANE_W];
    end
  end

endmodule

// File: rtl/perm_row_mix.sv
module perm_row_mix
  import perm_nl_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [NUM_LANES*LANE_W-1:0] src_state,
  output logic [NUM_LANES*LANE_W-1:0] dst_state
);

  for (genvar gy = 0; gy < ROW_LEN; gy++) begin : g_row
    for (genvar gx = 0; gx < ROW_LEN; gx++) begin : g_col
      localparam int SELF = lane_pos(gx, gy);
      localparam int NXT1 = lane_pos(row_step(gx, 1), gy);
      localparam int NXT2 = lane_pos(row_step(gx, 2), gy);
      logic [LANE_W-1:0] self_l, near_l, far_l;
      assign self_l = src_state[LANE_W*SELF +: LANE_W];
      assign near_l = src_state[LANE_W*NXT1 +: LANE_W];
      assign far_l  = src_state[LANE_W*NXT2 +: LANE_W];
      assign dst_state[LANE_W*SELF +: LANE_W] = self_l ^ (~near_l & far_l);
    end
  end

endmodule

// File: rtl/perm_const_inject.sv
module perm_const_inject
  import perm_nl_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [NUM_LANES*LANE_W-1:0] src_state,
  input  logic [LANE_W-1:0]           rc_lane,
  output logic [NUM_LANES*LANE_W-1:0] dst_state
);

  localparam int HI_W = (NUM_LANES - 1) * LANE_W;

  assign dst_state[LANE_W-1:0]               = src_state[LANE_W-1:0] ^ rc_lane;
  assign dst_state[LANE_W +: HI_W]           = src_state[LANE_W +: HI_W];

endmodule

// File: rtl/perm_nl_stage.sv
module perm_nl_stage
  import perm_nl_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [NUM_LANES*LANE_W-1:0] in_state,
  input  logic [LANE_W-1:0]           round_const,
  output logic                        out_valid,
  output logic [NUM_LANES*LANE_W-1:0] out_state
);

  localparam int STATE_W = NUM_LANES * LANE_W;

  // named internal events for the checks
  logic [STATE_W-1:0] shuffled;
  logic [STATE_W-1:0] mixed;
  logic [STATE_W-1:0] injected;
  logic               load_evt;

  assign load_evt = in_valid;

  perm_lane_shuffle #(.LANE_W(LANE_W)) u_shuffle (
    .src_state (in_state),
    .dst_state (shuffled)
  );

  perm_row_mix #(.LANE_W(LANE_W)) u_mix (
    .src_state (shuffled),
    .dst_state (mixed)
  );

  perm_const_inject #(.LANE_W(LANE_W)) u_inject (
    .src_state (mixed),
    .rc_lane   (round_const),
    .dst_state (injected)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load_evt) out_state <= injected;
  end

  // the rearrangement only moves bits, so the weight is kept
  always_comb begin
    if (!rst) begin
      AST_SHUFFLE_WEIGHT: assert ($countones(shuffled) == $countones(in_state))
        else $error("lane rearrangement changed the state weight"); // R2
    end
  end

  // a mixed bit may differ from its source only where the far neighbour is set
  always_comb begin
    if (!rst) begin
      for (int yy = 0; yy < ROW_LEN; yy++) begin
        for (int xx = 0; xx < ROW_LEN; xx++) begin
          AST_MIX_FLIP_GATED: assert (((mixed[LANE_W*lane_pos(xx, yy) +: LANE_W]
                                      ^ shuffled[LANE_W*lane_pos(xx, yy) +: LANE_W])
                                     & ~shuffled[LANE_W*lane_pos(row_step(xx, 2), yy) +: LANE_W]) == '0)
            else $error("row mix flipped a bit whose far neighbour is clear"); // R3
        end
      end
    end
  end

  // the injection touches lane (0,0) only and flips exactly the constant bits
  always_comb begin
    if (!rst) begin
      AST_CONST_LANE_ONLY: assert (((injected ^ mixed) >> LANE_W) == '0)
        else $error("round constant reached a lane other than (0,0)"); // R4
      AST_CONST_VALUE: assert ((injected[LANE_W-1:0] ^ mixed[LANE_W-1:0]) == round_const)
        else $error("lane (0,0) not flipped by the round constant"); // R4
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> out_state == $past(injected)); // R6

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_state)); // R8

endmodule

// File: tb/sim_perm_nl_stage.sv
module sim_perm_nl_stage;

  localparam int CLK_PERIOD = 10;
  localparam int LW         = 4;
  localparam int SW         = 25 * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_state = '0;
  logic [LW-1:0] rc = '0;
  logic          out_valid;
  logic [SW-1:0] out_state;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_nl_stage #(.LANE_W(LW)) u0 (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_state    (in_state),
    .round_const (rc),
    .out_valid   (out_valid),
    .out_state   (out_state)
  );

  function automatic logic bit_at(input logic [SW-1:0] a, input int x, input int y, input int z);
    return a[LW*(5*y+x)+z];
  endfunction

  // bit of the rearranged state at (x,y,z)
  function automatic logic moved(input logic [SW-1:0] a, input int x, input int y, input int z);
    return bit_at(a, (x + 3*y) % 5, x, z);
  endfunction

  function automatic logic [SW-1:0] model(input logic [SW-1:0] a, input logic [LW-1:0] k);
    logic [SW-1:0] r;
    r = '0;
    for (int z = 0; z < LW; z++)
      for (int y = 0; y < 5; y++)
        for (int x = 0; x < 5; x++) begin
          logic b;
          b = moved(a, x, y, z) ^ (!moved(a, (x+1)%5, y, z) & moved(a, (x+2)%5, y, z));
          if (x == 0 && y == 0) b = b ^ k[z];
          r[LW*(5*y+x)+z] = b;
        end
    return r;
  endfunction

  function automatic logic [31:0] xs32(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] s, input logic [LW-1:0] k, input string req);
    logic [SW-1:0] exp;
    exp = model(s, k);
    @(negedge clk);
    in_valid = 1'b1;
    in_state = s;
    rc       = k;
    @(negedge clk);
    check(out_valid === 1'b1, {req, " R7 valid"}, SW'(out_valid), SW'(1));
    check(out_state === exp, req, out_state, exp);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [SW-1:0] v;
    logic [SW-1:0] held;
    logic [15:0]   pat;

    // reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R7 reset", SW'(out_valid), SW'(0));
    rst = 1'b0;

    // R1: lane (1,0) goes to (0,2), whose row mix copies it into (3,2)
    v = '0;
    v[LW +: LW] = 4'b1011;
    begin
      logic [SW-1:0] e;
      e = '0;
      e[LW*10 +: LW] = 4'b1011;
      e[LW*13 +: LW] = 4'b1011;
      @(negedge clk);
      in_valid = 1'b1; in_state = v; rc = '0;
      @(negedge clk);
      check(out_state === e, "R1 R2 lane layout", out_state, e);
    end

    // R2 R3 R5: walk one set bit over every position
    for (int i = 0; i < SW; i++) begin
      v = '0;
      v[i] = 1'b1;
      send(v, '0, "R2 R3 R5 walking bit");
    end

    // R3 R5: walk one clear bit over an all-ones state
    for (int i = 0; i < SW; i += 3) begin
      v = '1;
      v[i] = 1'b0;
      send(v, LW'(i), "R3 R5 walking hole");
    end

    // R4: every constant on a zero state and on an all-ones state
    for (int k = 0; k < (1 << LW); k++) begin
      send('0, LW'(k), "R4 constant on zero");
      send('1, LW'(k), "R4 constant on ones");
    end

    // R6: pseudo-random states and constants
    for (int n = 0; n < 300; n++) begin
      for (int w = 0; w < SW; w += 32) begin
        seed = xs32(seed);
        for (int b = 0; b < 32; b++)
          if (w + b < SW) v[w+b] = seed[b];
      end
      seed = xs32(seed);
      send(v, seed[LW-1:0], "R3 R6 random");
    end

    // R8: hold while idle
    v = model(in_state, rc);
    held = v;
    in_valid = 1'b0;
    in_state = ~in_state;
    rc = ~rc;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(out_state === held, "R8 hold when idle", out_state, held);
      check(out_valid === 1'b0, "R7 idle valid", SW'(out_valid), SW'(0));
      in_state = in_state ^ SW'(c + 5);
    end

    // R7: valid pattern delayed by one cycle
    pat = 16'b1011_0010_1110_0101;
    for (int i = 0; i < 16; i++) begin
      in_valid = pat[i];
      @(negedge clk);
      check(out_valid === pat[i], "R7 valid delay", SW'(out_valid), SW'(pat[i]));
    end

    // R7: reset wins over a valid strobe
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R7 reset over valid", SW'(out_valid), SW'(0));
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b1, "R7 valid after reset", SW'(out_valid), SW'(1));
    in_valid = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule